// File: doc/BRIEF.md
# Three-Bank Selectable Clock Divider

This block takes one fast source clock and hands divided copies of it to three independent output banks. A bypass input picks the source: the oscillator-side clock in normal operation, or a single-ended reference clock when the on-chip synthesis path is to be skipped. Each bank divides the chosen source by 2, 4 or 5 according to its own 2-bit select code, and drives its result onto a group of true/complement pairs. The groups hold six, two and two pairs.

Each bank has an active-high enable. When the enable is low, or the select code is the reserved value, the bank's pairs are held static with the true side low and the complement side high. The divide-by-5 ratio still gives a 50% duty cycle, because the high phase is stretched by half a source cycle with a falling-edge register. A select or enable change is applied only at the end of the bank's current divided period, so no output pulse is ever cut short.

An active-high master reset clears all divider state at once. After reset is released, all banks start their count on the same source edge, so banks running at the same ratio stay edge-aligned. With a 625 MHz source the three ratios give 312.5, 156.25 and 125 MHz.

Top module: `clkdiv_banks`

## Requirements
- R1: Select code value 1 divides the source by 2, value 2 by 4 and value 3 by 5 (code written as sel[1:0]). Each bank follows only its own select.
- R2: For ratios 2 and 4 the true output is high for exactly half the period. For ratio 5 it is high for 2.5 source cycles.
- R3: Select code 0 parks the bank. Its true outputs stay low, its complement outputs stay high, and its count is held at zero.
- R4: With the bank enable low, the bank's true outputs stay low and its complement outputs stay high.
- R5: Every pair in a bank carries the same clock, and each complement output is always the inverse of its true output.
- R6: When bypass is high, the banks divide the reference clock instead of the oscillator clock.
- R7: While the master reset is high, all true outputs are low and all complement outputs are high, at once and without waiting for a clock edge.
- R8: A select or enable change takes effect only at the end of the current divided period, so a high pulse already in progress completes at its full length.
- R9: After reset is released, banks set to the same ratio with the same enable produce identical, edge-aligned outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Oscillator-side source clock |
| refClk | input | 1 | Reference source clock used in bypass |
| bypass | input | 1 | High selects refClk as the source |
| masterRst | input | 1 | Asynchronous active-high reset of all banks |
| selA | input | 2 | Bank A ratio code (0 park, 1 ÷2, 2 ÷4, 3 ÷5) |
| selB | input | 2 | Bank B ratio code |
| selC | input | 2 | Bank C ratio code |
| oeA | input | 1 | Bank A output enable, active high |
| oeB | input | 1 | Bank B output enable, active high |
| oeC | input | 1 | Bank C output enable, active high |
| aTrue | output | 6 | Bank A true outputs |
| aComp | output | 6 | Bank A complement outputs |
| bTrue | output | 2 | Bank B true outputs |
| bComp | output | 2 | Bank B complement outputs |
| cTrue | output | 2 | Bank C true outputs |
| cComp | output | 2 | Bank C complement outputs |

## Verification
The hardest case to reach is a configuration change that lands in the middle of a high pulse. In that case the output must finish the pulse at the old length and only then switch ratio or go quiet. The stimulus waits for a rising edge on the bank output and changes the select or enable a few nanoseconds later. It then measures the exact time of the following falling edge, so a pulse cut short at the source edge shows up as a wrong high time. Edge alignment between banks is only guaranteed when they leave reset together, so that test reasserts the master reset before sampling all three banks side by side.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    SEL_PARK = 2'd0,
    SEL_RAT1 = 2'd1,
    SEL_RAT2 = 2'd2,
    SEL_RAT3 = 2'd3
  } divSel_t;

  // strobes from a bank's control to its datapath, valid for the next source cycle
  typedef struct packed {
    logic hiNext;   // true output high during the next source cycle
    logic oddNext;  // active ratio is odd: stretch the high phase by half a cycle
  } bankStrobe_t;

endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import clkdiv_pkg::*;
#(
  parameter int DIV1 = 2,
  parameter int DIV2 = 4,
  parameter int DIV3 = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  selIn,
  input  logic        oeIn,
  output bankStrobe_t strobe
);

  localparam int MAX_DIV = (DIV1 > DIV2) ? ((DIV1 > DIV3) ? DIV1 : DIV3)
                                         : ((DIV2 > DIV3) ? DIV2 : DIV3);
  localparam int CNT_W   = $clog2(MAX_DIV);

  divSel_t          actSel;
  logic             actEn;
  logic [CNT_W-1:0] cnt;

  divSel_t          nxtSel;
  logic             nxtEn;
  logic [CNT_W-1:0] nxtCnt;
  logic             loadNow;

  function automatic int ratioOf(input divSel_t s);
    case (s)
      SEL_RAT1: ratioOf = DIV1;
      SEL_RAT2: ratioOf = DIV2;
      SEL_RAT3: ratioOf = DIV3;
      default:  ratioOf = 1;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] lastOf(input divSel_t s);
    lastOf = CNT_W'(ratioOf(s) - 1);
  endfunction

  function automatic logic [CNT_W-1:0] hiLenOf(input divSel_t s);
    hiLenOf = CNT_W'(ratioOf(s) / 2);
  endfunction

  always_comb begin
    loadNow = (actSel == SEL_PARK) || (cnt == lastOf(actSel));
    nxtSel  = loadNow ? divSel_t'(selIn) : actSel;
    nxtEn   = loadNow ? oeIn : actEn;
    nxtCnt  = loadNow ? '0 : cnt + 1'b1;
    strobe.hiNext  = (nxtSel != SEL_PARK) && nxtEn && (nxtCnt < hiLenOf(nxtSel));
    strobe.oddNext = (nxtSel != SEL_PARK) && (ratioOf(nxtSel) % 2 == 1);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      actSel <= SEL_PARK;
      actEn  <= 1'b0;
      cnt    <= '0;
    end else begin
      actSel <= nxtSel;
      actEn  <= nxtEn;
      cnt    <= nxtCnt;
    end
  end

endmodule

// File: rtl/bank_dp.sv
module bank_dp
  import clkdiv_pkg::*;
#(
  parameter int PAIRS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  bankStrobe_t      strobe,
  output logic [PAIRS-1:0] qTrue,
  output logic [PAIRS-1:0] qComp
);

  logic hiRise;   // rising-edge phase register
  logic oddRise;  // odd ratio in effect for this phase
  logic hiFall;   // half-cycle stretch register
  logic outBit;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hiRise  <= 1'b0;
      oddRise <= 1'b0;
    end else begin
      hiRise  <= strobe.hiNext;
      oddRise <= strobe.oddNext;
    end
  end

  always_ff @(negedge clk or posedge rst) begin
    if (rst) hiFall <= 1'b0;
    else     hiFall <= hiRise & oddRise;
  end

  assign outBit = hiRise | hiFall;

  for (genvar g = 0; g < PAIRS; g++) begin : gPair
    assign qTrue[g] = outBit;
    assign qComp[g] = ~outBit;
  end

endmodule

// File: rtl/div_bank.sv
module div_bank
  import clkdiv_pkg::*;
#(
  parameter int PAIRS = 2,
  parameter int DIV1  = 2,
  parameter int DIV2  = 4,
  parameter int DIV3  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       selIn,
  input  logic             oeIn,
  output logic [PAIRS-1:0] qTrue,
  output logic [PAIRS-1:0] qComp
);

  bankStrobe_t strobe;

  bank_ctrl #(.DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .selIn  (selIn),
    .oeIn   (oeIn),
    .strobe (strobe)
  );

  bank_dp #(.PAIRS(PAIRS)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .qTrue  (qTrue),
    .qComp  (qComp)
  );

endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks #(
  parameter int A_PAIRS = 6,
  parameter int B_PAIRS = 2,
  parameter int C_PAIRS = 2,
  parameter int DIV1    = 2,
  parameter int DIV2    = 4,
  parameter int DIV3    = 5
) (
  input  logic               oscClk,
  input  logic               refClk,
  input  logic               bypass,
  input  logic               masterRst,
  input  logic [1:0]         selA,
  input  logic [1:0]         selB,
  input  logic [1:0]         selC,
  input  logic               oeA,
  input  logic               oeB,
  input  logic               oeC,
  output logic [A_PAIRS-1:0] aTrue,
  output logic [A_PAIRS-1:0] aComp,
  output logic [B_PAIRS-1:0] bTrue,
  output logic [B_PAIRS-1:0] bComp,
  output logic [C_PAIRS-1:0] cTrue,
  output logic [C_PAIRS-1:0] cComp
);

  logic srcClk;
  assign srcClk = bypass ? refClk : oscClk;

  div_bank #(.PAIRS(A_PAIRS), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_bankA (
    .clk(srcClk), .rst(masterRst), .selIn(selA), .oeIn(oeA),
    .qTrue(aTrue), .qComp(aComp)
  );

  div_bank #(.PAIRS(B_PAIRS), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_bankB (
    .clk(srcClk), .rst(masterRst), .selIn(selB), .oeIn(oeB),
    .qTrue(bTrue), .qComp(bComp)
  );

  div_bank #(.PAIRS(C_PAIRS), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_bankC (
    .clk(srcClk), .rst(masterRst), .selIn(selC), .oeIn(oeC),
    .qTrue(cTrue), .qComp(cComp)
  );

endmodule

// File: rtl/clkdiv_banks_chk.sv
module clkdiv_banks_chk (
  input logic       srcClk,
  input logic       masterRst,
  input logic [1:0] selA,
  input logic [1:0] selB,
  input logic       oeA,
  input logic       oeB,
  input logic       qa0,
  input logic       qb0
);

  logic [2:0] parkRun;
  logic [2:0] offRun;
  logic [1:0] hiRun;
  logic       sameSinceRst;
  logic       sameNow;

  assign sameNow = sameSinceRst && (selA == selB) && (oeA == oeB);

  always_ff @(posedge srcClk or posedge masterRst) begin
    if (masterRst) begin
      parkRun      <= '0;
      offRun       <= '0;
      hiRun        <= '0;
      sameSinceRst <= 1'b1;
    end else begin
      parkRun      <= (selA != 2'd0) ? 3'd0 : ((parkRun == 3'd7) ? parkRun : parkRun + 3'd1);
      offRun       <= oeA ? 3'd0 : ((offRun == 3'd7) ? offRun : offRun + 3'd1);
      hiRun        <= qa0 ? ((hiRun == 2'd3) ? hiRun : hiRun + 2'd1) : 2'd0;
      sameSinceRst <= sameNow;
    end
  end

  // R7
  always @(negedge srcClk) begin
    if (masterRst) begin
      rst_quiet_chk: assert (!qa0 && !qb0);
    end
  end

  // R3
  park_quiet_chk: assert property (@(posedge srcClk) disable iff (masterRst)
    (parkRun >= 3'd6) |-> !qa0);

  // R4
  disable_quiet_chk: assert property (@(posedge srcClk) disable iff (masterRst)
    (offRun >= 3'd6) |-> !qa0);

  // R2
  high_len_chk: assert property (@(posedge srcClk) disable iff (masterRst)
    !(qa0 && hiRun >= 2'd2));

  // R9
  bank_align_chk: assert property (@(posedge srcClk) disable iff (masterRst)
    sameNow |-> (qa0 == qb0));

endmodule

bind clkdiv_banks clkdiv_banks_chk u_chk (
  .srcClk    (srcClk),
  .masterRst (masterRst),
  .selA      (selA),
  .selB      (selB),
  .oeA       (oeA),
  .oeB       (oeB),
  .qa0       (aTrue[0]),
  .qb0       (bTrue[0])
);

// File: tb/tb_clkdiv_banks.sv
`timescale 1ns/1ps
module tb_clkdiv_banks;

  localparam int PERIOD = 10;

  logic oscClk = 1'b0;
  logic refClk = 1'b0;
  logic bypass = 1'b0;
  logic masterRst = 1'b1;
  logic [1:0] selA = 2'd0, selB = 2'd0, selC = 2'd0;
  logic oeA = 1'b1, oeB = 1'b1, oeC = 1'b1;
  logic [5:0] aTrue, aComp;
  logic [1:0] bTrue, bComp, cTrue, cComp;

  int nChecks = 0;
  int nErr = 0;
  logic [1:0] probeSel = 2'd0;
  logic probe;

  clkdiv_banks dut (
    .oscClk(oscClk), .refClk(refClk), .bypass(bypass), .masterRst(masterRst),
    .selA(selA), .selB(selB), .selC(selC), .oeA(oeA), .oeB(oeB), .oeC(oeC),
    .aTrue(aTrue), .aComp(aComp), .bTrue(bTrue), .bComp(bComp),
    .cTrue(cTrue), .cComp(cComp)
  );

  always #(PERIOD/2) oscClk = ~oscClk;
  always #(PERIOD)   refClk = ~refClk;

  always_comb begin
    case (probeSel)
      2'd0:    probe = aTrue[0];
      2'd1:    probe = bTrue[0];
      default: probe = cTrue[0];
    endcase
  end

  // {selA, selB, selC, oeA, oeB, oeC}
  localparam logic [8:0] VEC [6] = '{
    {2'd1, 2'd2, 2'd3, 3'b111},
    {2'd3, 2'd1, 2'd2, 3'b111},
    {2'd2, 2'd3, 2'd0, 3'b111},
    {2'd1, 2'd1, 2'd1, 3'b101},
    {2'd0, 2'd2, 2'd3, 3'b110},
    {2'd3, 2'd3, 2'd3, 3'b111}
  };

  function automatic int ratioOf(input logic [1:0] code);
    case (code)
      2'd1:    ratioOf = 2;
      2'd2:    ratioOf = 4;
      2'd3:    ratioOf = 5;
      default: ratioOf = 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0.1f expected %0.1f", req, what, act, exp);
    end
  endtask

  task automatic measure(input int b, output real hi, output real per);
    real t0, t1, t2;
    probeSel = 2'(b);
    #1;
    @(posedge probe); t0 = $realtime;
    @(negedge probe); t1 = $realtime;
    @(posedge probe); t2 = $realtime;
    hi = t1 - t0;
    per = t2 - t0;
  endtask

  task automatic getBank(input int b, output logic [5:0] t, output logic [5:0] c,
                         output logic [5:0] mask);
    case (b)
      0:       begin t = aTrue;         c = aComp;         mask = 6'h3f; end
      1:       begin t = {4'd0, bTrue}; c = {4'd0, bComp}; mask = 6'h03; end
      default: begin t = {4'd0, cTrue}; c = {4'd0, cComp}; mask = 6'h03; end
    endcase
  endtask

  task automatic staticCheck(input int b, input string req);
    logic [5:0] t, c, m;
    bit ok = 1'b1;
    for (int i = 0; i < 24; i++) begin
      #(PERIOD/2 - 2);
      getBank(b, t, c, m);
      if ((t & m) != 6'd0 || (c & m) != m) ok = 1'b0;
      #2;
    end
    chk(ok, req, $sformatf("bank %0d held static low/high", b), real'(t), 0.0);
  endtask

  task automatic pairCheck(input int b);
    logic [5:0] t, c, m;
    bit ok = 1'b1;
    for (int i = 0; i < 12; i++) begin
      #3;
      getBank(b, t, c, m);
      if (((t & m) != 6'd0 && (t & m) != m) || ((c ^ t) & m) != m) ok = 1'b0;
    end
    chk(ok, "R5", $sformatf("bank %0d pairs equal and inverted", b), real'(t), 0.0);
  endtask

  initial begin
    #(PERIOD * 150000);
    nErr++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    real hi, per;
    logic [5:0] t, c, m;
    bit ok;

    // R7: reset state
    #(PERIOD * 3 + 2);
    for (int b = 0; b < 3; b++) begin
      getBank(b, t, c, m);
      chk((t & m) == 0 && (c & m) == m, "R7", $sformatf("reset state bank %0d", b), real'(t), 0.0);
    end
    @(negedge oscClk);
    masterRst = 1'b0;

    // vector table: R1 ratios, R2 duty, R3 park, R4 disable, R5 pairs
    for (int i = 0; i < 6; i++) begin
      @(negedge oscClk);
      {selA, selB, selC, oeA, oeB, oeC} = VEC[i];
      repeat (30) @(negedge oscClk);
      for (int b = 0; b < 3; b++) begin
        logic [1:0] code;
        logic en;
        code = VEC[i][8 - 2*b -: 2];
        en   = VEC[i][2 - b];
        if (code == 2'd0) staticCheck(b, "R3");
        else if (!en) staticCheck(b, "R4");
        else begin
          measure(b, hi, per);
          chk(per == real'(ratioOf(code) * PERIOD), "R1",
              $sformatf("vec %0d bank %0d period", i, b), per, real'(ratioOf(code) * PERIOD));
          chk(hi == real'(ratioOf(code) * PERIOD) / 2.0, "R2",
              $sformatf("vec %0d bank %0d high time", i, b), hi, real'(ratioOf(code) * PERIOD) / 2.0);
          pairCheck(b);
        end
      end
    end

    // R8: ratio change in the middle of a high pulse
    @(negedge oscClk);
    selA = 2'd2; selB = 2'd2; selC = 2'd2; oeA = 1'b1; oeB = 1'b1; oeC = 1'b1;
    repeat (30) @(negedge oscClk);
    probeSel = 2'd0;
    #1;
    @(posedge probe);
    hi = $realtime;
    #3 selA = 2'd1;
    @(negedge probe);
    hi = $realtime - hi;
    chk(hi == 20.0, "R8", "pulse completes after ratio change", hi, 20.0);
    measure(0, hi, per);
    chk(per == 20.0, "R8", "new ratio applied at period end", per, 20.0);

    // R8: disable in the middle of a high pulse on ratio 5
    @(negedge oscClk);
    selA = 2'd3;
    repeat (30) @(negedge oscClk);
    #1;
    @(posedge probe);
    hi = $realtime;
    #3 oeA = 1'b0;
    @(negedge probe);
    hi = $realtime - hi;
    chk(hi == 25.0, "R8", "pulse completes after disable", hi, 25.0);
    staticCheck(0, "R4");

    // R7: asynchronous reset while running
    @(negedge oscClk);
    oeA = 1'b1; selA = 2'd2;
    repeat (30) @(negedge oscClk);
    probeSel = 2'd0;
    #1;
    @(posedge probe);
    #2 masterRst = 1'b1;
    #1;
    ok = 1'b1;
    for (int b = 0; b < 3; b++) begin
      getBank(b, t, c, m);
      if ((t & m) != 0 || (c & m) != m) ok = 1'b0;
    end
    chk(ok, "R7", "outputs cleared without a clock edge", real'(aTrue), 0.0);

    // R9: banks aligned after reset release
    selA = 2'd3; selB = 2'd3; selC = 2'd3;
    repeat (3) @(negedge oscClk);
    masterRst = 1'b0;
    repeat (4) @(negedge oscClk);
    ok = 1'b1;
    for (int i = 0; i < 60; i++) begin
      #(PERIOD/2 - 2);
      if (aTrue[0] != bTrue[0] || aTrue[0] != cTrue[0]) ok = 1'b0;
      #2;
    end
    chk(ok, "R9", "same-ratio banks edge aligned", real'(bTrue[0]), real'(aTrue[0]));

    // R6: bypass selects the reference clock (period 2*PERIOD)
    masterRst = 1'b1;
    bypass = 1'b1;
    selA = 2'd2; selB = 2'd1; selC = 2'd3;
    repeat (3) @(negedge refClk);
    #2 masterRst = 1'b0;
    repeat (20) @(negedge refClk);
    measure(0, hi, per);
    chk(per == real'(4 * 2 * PERIOD), "R6", "bank A period on reference", per, real'(4 * 2 * PERIOD));
    measure(2, hi, per);
    chk(per == real'(5 * 2 * PERIOD), "R6", "bank C period on reference", per, real'(5 * 2 * PERIOD));
    chk(hi == real'(5 * PERIOD), "R2", "bank C ratio 5 high time on reference", hi, real'(5 * PERIOD));

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule